// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is one dual-address DMA channel. Each transfer reads one word from a source address and then writes the same word to a destination address over a simple internal request/acknowledge bus. The channel keeps its own source pointer, destination pointer, transfer counter and block-size counter. Each of these is updated in the preparation clock that comes before the bus access it belongs to, so a register read during a pending access already returns the post-update value.

Three transfer modes are available. Normal mode runs a fixed number of transfers and then stops. Repeat mode runs forever and rewinds the counter and one chosen pointer each time the counter runs out. Block mode moves a number of fixed-size blocks and rewinds the chosen pointer and the block-size counter after each block. A finished sequence is followed by one quiet clock that carries a one-clock `done` pulse. Software sets the channel up through a small register port, and it can stop a running channel by clearing the enable bit.

Top module: `dma_chan_seq`

## Requirements
- R1: The source pointer, transfer counter and block-size counter are updated in the clock before the read request is raised. While a read is pending, `bus_addr` holds the value the pointer had before the update, and a readback of the pointer (offset 0) or the counter (offset 2) already shows the updated value.
- R2: The source step is set by control bits [4:3]: 0 = fixed, 1 = increment, 2 = decrement, 3 = fixed. The step is 1, 2 or 4 bytes for size bits [8:7] = 0, 1 and 2 (3 is treated as 4). The update happens after each use of the pointer.
- R3: The destination pointer (offset 1) is stepped by control bits [6:5], using the same encoding as R2 and independently of the source.
- R4: Each transfer is a read from the source pointer and then a write to the destination pointer, with the data that was read. A request keeps its address and direction until it is acknowledged, and it drops in the clock after the acknowledge.
- R5: In normal mode (bits [2:1] = 0), the channel performs COUNT (offset 2) transfers, and COUNT decreases by one per transfer. A programmed COUNT of 0 means 65536 transfers, so the first transfer leaves 0xFFFF.
- R6: In repeat mode (bits [2:1] = 1), when COUNT would reach zero, both COUNT and the selected area pointer are reloaded with their programmed values, and the transfers go on.
- R7: In block mode (bits [2:1] = 2), BSIZE (offset 3) decreases on each transfer. On the last transfer of a block, BSIZE is reloaded, the area pointer is rewound and COUNT decreases by one. The operation ends after COUNT blocks.
- R8: After the final transfer of a normal-mode or block-mode operation, the channel spends exactly one clock with no bus request. `done` is high for only that clock, in the clock after the final write acknowledge, and the enable bit (control bit 0) then reads 0.
- R9: While the channel is enabled or busy, writes to offsets 0 to 3 and control writes with bit 0 set have no effect.
- R10: Writing the control register with bit 0 clear while the channel is enabled finishes the current read/write pair and then returns to idle, with no dead clock and no `done` pulse. The pointers and counters keep the values they hold at that point.
- R11: Control bit 9 selects the area pointer that is rewound in repeat and block modes: 0 selects the source pointer and 1 selects the destination pointer.
- R12: After reset, all readable registers are zero, no bus request is pending and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset, used for both reads and writes |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered readback of the register at `reg_addr` |
| bus_req | output | 1 | Bus access request |
| bus_wr | output | 1 | 1 = write access, 0 = read access |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data, captured from the preceding read |
| bus_rdata | input | DW | Read data, sampled when a read is acknowledged |
| bus_ack | input | 1 | Access acknowledge |
| done | output | 1 | One-clock completion pulse |

## Verification
The first read request appears on the bus two clocks after the write that enables the channel. The first clock loads the enable bit and the second is the preparation clock. A register readback is valid one clock after its offset is presented. `done` rises in the clock right after the final write acknowledge. The bench drives every input and samples every output on the falling edge. It uses a behavioural model to build queues of the expected read and write accesses and the expected final register values. Each acknowledged access is compared with the head of the queue at the moment it is acknowledged. Wait states are added so that the readbacks taken during a pending read (R1) fall inside that read.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

  typedef enum logic [1:0] {
    XM_NORMAL = 2'd0,
    XM_REPEAT = 2'd1,
    XM_BLOCK  = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    AS_FIXED = 2'd0,
    AS_INC   = 2'd1,
    AS_DEC   = 2'd2,
    AS_HOLD  = 2'd3
  } addr_step_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD_PREP,
    SQ_RD,
    SQ_WR_PREP,
    SQ_WR,
    SQ_DEAD
  } seq_state_e;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_BLK  = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;

  localparam int CB_EN   = 0;
  localparam int CB_MODE = 1;
  localparam int CB_SDIR = 3;
  localparam int CB_DDIR = 5;
  localparam int CB_SIZE = 7;
  localparam int CB_AREA = 9;
  localparam int CB_W    = 10;

endpackage

// File: rtl/dmaseq_addr_reg.sv
module dmaseq_addr_reg
  import dmaseq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          adv,
  input  logic          restore,
  input  addr_step_e    dir,
  input  logic [1:0]    size,
  output logic [AW-1:0] cur
);

  logic [AW-1:0] init_q;
  logic [AW-1:0] step;
  logic [1:0]    sz_eff;

  always_comb begin
    sz_eff = (size == 2'd3) ? 2'd2 : size;
    step   = AW'(3'(3'd1 << sz_eff));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur    <= '0;
      init_q <= '0;
    end else if (ld) begin
      cur    <= ld_val;
      init_q <= ld_val;
    end else if (adv) begin
      if (restore) begin
        cur <= init_q;
      end else begin
        case (dir)
          AS_INC:  cur <= cur + step;
          AS_DEC:  cur <= cur - step;
          default: cur <= cur;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmaseq_counters.sv
module dmaseq_counters
  import dmaseq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_cnt,
  input  logic          ld_blk,
  input  logic [CW-1:0] ld_val,
  input  logic          adv,
  input  xfer_mode_e    mode,
  output logic [CW-1:0] tcnt,
  output logic [CW-1:0] bcnt,
  output logic          wrap,
  output logic          last
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] tinit_q;
  logic [CW-1:0] binit_q;

  // Decisions for the transfer being prepared now
  always_comb begin
    wrap = 1'b0;
    last = 1'b0;
    case (mode)
      XM_REPEAT: wrap = (tcnt == ONE);
      XM_BLOCK: begin
        wrap = (bcnt == ONE);
        last = (bcnt == ONE) && (tcnt == ONE);
      end
      default: last = (tcnt == ONE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt    <= '0;
      bcnt    <= '0;
      tinit_q <= '0;
      binit_q <= '0;
    end else begin
      if (ld_cnt) begin
        tcnt    <= ld_val;
        tinit_q <= ld_val;
      end
      if (ld_blk) begin
        bcnt    <= ld_val;
        binit_q <= ld_val;
      end
      if (adv) begin
        case (mode)
          XM_REPEAT: tcnt <= wrap ? tinit_q : tcnt - ONE;
          XM_BLOCK: begin
            if (wrap) begin
              bcnt <= binit_q;
              tcnt <= tcnt - ONE;
            end else begin
              bcnt <= bcnt - ONE;
            end
          end
          default: tcnt <= tcnt - ONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/dmaseq_ctrl.sv
module dmaseq_ctrl
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          stop_req,
  input  logic          wrap_in,
  input  logic          last_in,
  input  logic          area_dst,
  input  logic [AW-1:0] src_cur,
  input  logic [AW-1:0] dst_cur,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          src_adv,
  output logic          src_restore,
  output logic          dst_adv,
  output logic          dst_restore,
  output logic          cnt_adv,
  output logic          busy,
  output logic          fin,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          done
);

  seq_state_e state;
  logic       wrap_q;
  logic       last_q;
  logic       stop_q;
  logic       wr_end;

  always_comb begin
    src_adv     = (state == SQ_RD_PREP);
    cnt_adv     = (state == SQ_RD_PREP);
    src_restore = wrap_in && !area_dst;
    dst_adv     = (state == SQ_WR_PREP);
    dst_restore = wrap_q && area_dst;
    busy        = (state != SQ_IDLE);
    wr_end      = (state == SQ_WR) && bus_ack;
    fin         = wr_end && (last_q || stop_q || stop_req);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      wrap_q    <= 1'b0;
      last_q    <= 1'b0;
      stop_q    <= 1'b0;
      bus_req   <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stop_req) stop_q <= 1'b1;
      case (state)
        SQ_IDLE: begin
          if (start) state <= SQ_RD_PREP;
        end
        SQ_RD_PREP: begin
          bus_addr <= src_cur;
          bus_req  <= 1'b1;
          bus_wr   <= 1'b0;
          wrap_q   <= wrap_in;
          last_q   <= last_in;
          state    <= SQ_RD;
        end
        SQ_RD: begin
          if (bus_ack) begin
            bus_wdata <= bus_rdata;
            bus_req   <= 1'b0;
            state     <= SQ_WR_PREP;
          end
        end
        SQ_WR_PREP: begin
          bus_addr <= dst_cur;
          bus_req  <= 1'b1;
          bus_wr   <= 1'b1;
          state    <= SQ_WR;
        end
        SQ_WR: begin
          if (bus_ack) begin
            bus_req <= 1'b0;
            bus_wr  <= 1'b0;
            if (last_q) begin
              state  <= SQ_DEAD;
              done   <= 1'b1;
              stop_q <= 1'b0;
            end else if (stop_q || stop_req) begin
              state  <= SQ_IDLE;
              stop_q <= 1'b0;
            end else begin
              state <= SQ_RD_PREP;
            end
          end
        end
        SQ_DEAD: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dmaseq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          done
);

  localparam int NPTR = 2;   // 0: source, 1: destination

  logic       en_q;
  xfer_mode_e mode_q;
  addr_step_e sdir_q;
  addr_step_e ddir_q;
  logic [1:0] size_q;
  logic       area_q;

  logic busy, fin, cfg_open, ctrl_wr, stop_req;
  logic wrap, last;
  logic src_adv, src_restore, dst_adv, dst_restore, cnt_adv;
  logic [CW-1:0] tcnt, bcnt;

  logic [AW-1:0] ptr_cur [NPTR];
  logic          ptr_ld  [NPTR];
  logic          ptr_adv [NPTR];
  logic          ptr_rst [NPTR];
  addr_step_e    ptr_dir [NPTR];

  always_comb begin
    cfg_open   = !en_q && !busy;
    ctrl_wr    = reg_we && (reg_addr == RA_CTRL);
    stop_req   = ctrl_wr && en_q && !reg_wdata[CB_EN];
    ptr_ld[0]  = reg_we && (reg_addr == RA_SRC) && cfg_open;
    ptr_ld[1]  = reg_we && (reg_addr == RA_DST) && cfg_open;
    ptr_adv[0] = src_adv;
    ptr_adv[1] = dst_adv;
    ptr_rst[0] = src_restore;
    ptr_rst[1] = dst_restore;
    ptr_dir[0] = sdir_q;
    ptr_dir[1] = ddir_q;
  end

  generate
    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
      dmaseq_addr_reg #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld      (ptr_ld[g]),
        .ld_val  (reg_wdata),
        .adv     (ptr_adv[g]),
        .restore (ptr_rst[g]),
        .dir     (ptr_dir[g]),
        .size    (size_q),
        .cur     (ptr_cur[g])
      );
    end
  endgenerate

  dmaseq_counters #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .ld_cnt (reg_we && (reg_addr == RA_CNT) && cfg_open),
    .ld_blk (reg_we && (reg_addr == RA_BLK) && cfg_open),
    .ld_val (reg_wdata[CW-1:0]),
    .adv    (cnt_adv),
    .mode   (mode_q),
    .tcnt   (tcnt),
    .bcnt   (bcnt),
    .wrap   (wrap),
    .last   (last)
  );

  dmaseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (en_q),
    .stop_req    (stop_req),
    .wrap_in     (wrap),
    .last_in     (last),
    .area_dst    (area_q),
    .src_cur     (ptr_cur[0]),
    .dst_cur     (ptr_cur[1]),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .src_adv     (src_adv),
    .src_restore (src_restore),
    .dst_adv     (dst_adv),
    .dst_restore (dst_restore),
    .cnt_adv     (cnt_adv),
    .busy        (busy),
    .fin         (fin),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .done        (done)
  );

  // Control register: config is only taken while the channel is quiet
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= XM_NORMAL;
      sdir_q <= AS_FIXED;
      ddir_q <= AS_FIXED;
      size_q <= 2'd0;
      area_q <= 1'b0;
    end else begin
      if (ctrl_wr && cfg_open) begin
        en_q   <= reg_wdata[CB_EN];
        mode_q <= xfer_mode_e'(reg_wdata[CB_MODE +: 2]);
        sdir_q <= addr_step_e'(reg_wdata[CB_SDIR +: 2]);
        ddir_q <= addr_step_e'(reg_wdata[CB_DDIR +: 2]);
        size_q <= reg_wdata[CB_SIZE +: 2];
        area_q <= reg_wdata[CB_AREA];
      end
      if (stop_req || fin) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_SRC:  reg_rdata <= ptr_cur[0];
        RA_DST:  reg_rdata <= ptr_cur[1];
        RA_CNT:  reg_rdata <= AW'(tcnt);
        RA_BLK:  reg_rdata <= AW'(bcnt);
        RA_CTRL: reg_rdata <= AW'({area_q, size_q, ddir_q, sdir_q, mode_q, en_q});
        default: reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/dmaseq_chk.sv
module dmaseq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_wr,
  input logic          bus_ack,
  input logic [AW-1:0] bus_addr,
  input logic          done
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_wr));

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  // R4
  wr_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> bus_req);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  dead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

  // R8
  done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(bus_req && bus_wr && bus_ack));

endmodule

bind dma_chan_seq dmaseq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_wr   (bus_wr),
  .bus_ack  (bus_ack),
  .bus_addr (bus_addr),
  .done     (done)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_req, bus_wr, done;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  int lat = 1;
  int wcnt = 0;
  int cyc = 0;
  int last_wr_cyc = -10;
  int wr_seen = 0;
  int done_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] exp_rd[$];
  logic [31:0] exp_wr[$];
  logic [31:0] exp_src, exp_dst, exp_cnt, exp_blk;
  logic [31:0] rv;

  always #5 clk = ~clk;

  dma_chan_seq u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bus responder and per-access comparison against the model queues
  always @(negedge clk) begin
    cyc++;
    if (done) begin
      done_cnt++;
      chk(last_wr_cyc == cyc - 1, "R8 done one clock after final write ack", cyc, last_wr_cyc + 1);
      chk(!bus_req, "R8 no request in dead clock", 32'(bus_req), 0);
    end
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req && !rst) begin
      if (wcnt < lat) begin
        wcnt++;
      end else begin
        wcnt = 0;
        bus_ack = 1'b1;
        if (!bus_wr) begin
          if (exp_rd.size() == 0) chk(0, "R4 unexpected read", bus_addr, 0);
          else begin
            logic [31:0] e;
            e = exp_rd.pop_front();
            chk(bus_addr == e, "R4 read address", bus_addr, e);
          end
          last_rd_addr = bus_addr;
          bus_rdata = mem_val(bus_addr);
        end else begin
          if (exp_wr.size() == 0) chk(0, "R4 unexpected write", bus_addr, 0);
          else begin
            logic [31:0] e;
            e = exp_wr.pop_front();
            chk(bus_addr == e, "R4 write address", bus_addr, e);
          end
          chk(bus_wdata == mem_val(last_rd_addr), "R4 write data", bus_wdata, mem_val(last_rd_addr));
          wr_seen++;
          last_wr_cyc = cyc;
        end
      end
    end
  end

  // Behavioural model: expected access lists and final register values
  task automatic model(input logic [31:0] s0, input logic [31:0] d0, input int mode,
                       input int sdir, input int ddir, input int size, input int area,
                       input int cnt, input int bsz, input int n);
    logic [31:0] s, d, st, sd, dd;
    int t, b, tinit, binit;
    bit wrap;
    s = s0; d = d0;
    st = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    sd = (sdir == 1) ? st : (sdir == 2) ? -st : 0;
    dd = (ddir == 1) ? st : (ddir == 2) ? -st : 0;
    t = (cnt == 0) ? 65536 : cnt;
    b = (bsz == 0) ? 65536 : bsz;
    tinit = t; binit = b;
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(s);
      exp_wr.push_back(d);
      wrap = 0;
      if (mode == 1) begin
        t--; if (t == 0) begin wrap = 1; t = tinit; end
      end else if (mode == 2) begin
        b--; if (b == 0) begin wrap = 1; b = binit; t--; end
      end else t--;
      s = (wrap && area == 0) ? s0 : s + sd;
      d = (wrap && area == 1) ? d0 : d + dd;
    end
    exp_src = s; exp_dst = d;
    exp_cnt = 32'(t % 65536);
    exp_blk = 32'(bsz);
    if (mode == 2) exp_blk = 32'(b % 65536);
  endtask

  function automatic logic [31:0] cw(input int mode, input int sdir, input int ddir,
                                     input int size, input int area, input bit en);
    return {22'd0, 1'(area), 2'(size), 2'(ddir), 2'(sdir), 2'(mode), en};
  endfunction

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input int cnt, input int bsz);
    reg_wr(3'd0, s); reg_wr(3'd1, d); reg_wr(3'd2, 32'(cnt)); reg_wr(3'd3, 32'(bsz));
    done_cnt = 0; wr_seen = 0;
  endtask

  task automatic drain();
    wait (exp_wr.size() == 0);
    repeat (5) @(negedge clk);
    chk(exp_rd.size() == 0, "R4 all reads seen", exp_rd.size(), 0);
  endtask

  task automatic check_regs(input string tag);
    reg_rd(3'd0, rv); chk(rv == exp_src, {tag, " source pointer"}, rv, exp_src);
    reg_rd(3'd1, rv); chk(rv == exp_dst, {tag, " destination pointer"}, rv, exp_dst);
    reg_rd(3'd2, rv); chk(rv == exp_cnt, {tag, " count"}, rv, exp_cnt);
    reg_rd(3'd3, rv); chk(rv == exp_blk, {tag, " block size"}, rv, exp_blk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk(!bus_req && !done, "R12 outputs idle", {bus_req, done}, 0);
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), rv);
      chk(rv == 0, "R12 register zero", rv, 0);
    end

    // R2 R3 R5 R8: normal, both incrementing, 4-byte step
    setup(32'h1000, 32'h2000, 3, 0);
    model(32'h1000, 32'h2000, 0, 1, 1, 2, 0, 3, 0, 3);
    reg_wr(3'd4, cw(0, 1, 1, 2, 0, 1));
    drain();
    check_regs("R5 normal inc");
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    reg_rd(3'd4, rv);
    chk(rv == 32'h128, "R8 enable cleared", rv, 32'h128);

    // R2 R3: source decrement, destination fixed, 2-byte step
    setup(32'h3000, 32'h4000, 4, 0);
    model(32'h3000, 32'h4000, 0, 2, 0, 1, 0, 4, 0, 4);
    reg_wr(3'd4, cw(0, 2, 0, 1, 0, 1));
    drain();
    check_regs("R2 R3 dec/fixed");

    // R1: update lands in the preparation clock before the read
    lat = 3;
    setup(32'h0500, 32'h0600, 2, 0);
    model(32'h0500, 32'h0600, 0, 1, 1, 0, 0, 2, 0, 2);
    reg_wr(3'd4, cw(0, 1, 1, 0, 0, 1));
    do @(negedge clk); while (!bus_req);
    reg_addr = 3'd0;
    @(negedge clk);
    chk(reg_rdata == 32'h0501, "R1 source already advanced", reg_rdata, 32'h0501);
    chk(bus_addr == 32'h0500 && bus_req, "R1 bus holds old address", bus_addr, 32'h0500);
    reg_addr = 3'd2;
    @(negedge clk);
    chk(reg_rdata == 32'd1, "R1 count already decremented", reg_rdata, 1);
    drain();
    lat = 1;

    // R6 R10 R11: repeat with source area, stopped during third pair
    setup(32'h8000, 32'h9000, 2, 0);
    model(32'h8000, 32'h9000, 1, 1, 1, 1, 0, 2, 0, 3);
    reg_wr(3'd4, cw(1, 1, 1, 1, 0, 1));
    wait (wr_seen == 2);
    reg_wr(3'd4, 32'd0);
    drain();
    check_regs("R6 R11 repeat source area");
    chk(done_cnt == 0, "R10 no done on stop", done_cnt, 0);
    chk(wr_seen == 3, "R10 current pair completed", wr_seen, 3);
    repeat (10) @(negedge clk);
    chk(!bus_req, "R10 stays idle", 32'(bus_req), 0);

    // R7 R11: block mode, destination area, 2 blocks of 3
    setup(32'h6000, 32'h7000, 2, 3);
    model(32'h6000, 32'h7000, 2, 1, 1, 0, 1, 2, 3, 6);
    reg_wr(3'd4, cw(2, 1, 1, 0, 1, 1));
    drain();
    check_regs("R7 R11 block destination area");
    chk(done_cnt == 1, "R7 done after last block", done_cnt, 1);

    // R9: writes while running are ignored
    setup(32'hA000, 32'hB000, 4, 0);
    model(32'hA000, 32'hB000, 0, 1, 1, 2, 0, 4, 0, 4);
    reg_wr(3'd4, cw(0, 1, 1, 2, 0, 1));
    reg_wr(3'd0, 32'hDEAD_0000);
    reg_wr(3'd2, 32'd9);
    reg_wr(3'd4, cw(1, 2, 2, 0, 1, 1));
    drain();
    check_regs("R9 ignored writes");
    reg_rd(3'd4, rv);
    chk(rv == 32'h128, "R9 control unchanged", rv, 32'h128);

    // R5 R10: count of zero means 65536, stop right after start
    setup(32'hC000, 32'hD000, 0, 0);
    model(32'hC000, 32'hD000, 0, 1, 1, 2, 0, 0, 0, 1);
    reg_wr(3'd4, cw(0, 1, 1, 2, 0, 1));
    reg_wr(3'd4, 32'd0);
    drain();
    check_regs("R5 zero count");
    chk(done_cnt == 0, "R10 no done", done_cnt, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule